// File: doc/BRIEF.md
# DRAM Bank Access Sequencer

This block drives a single DRAM bank of 1024 rows, each 2048 bits wide, read and written in 256-bit column groups. Each request names a row, a 3-bit column group and a direction. When the addressed row is not the one currently held open, the block runs the whole row cycle. That cycle has four phases in fixed order: bitline precharge, sense-amplifier readout, cell restore and column access. Each phase lasts a parameterised number of clock cycles. The defaults (2, 2, 3 and 1 at 100 MHz) come from phase times of roughly 15, 20, 25 and 10 ns, rounded up.

The sensed row stays in a row buffer after the cycle. A later request to the same row goes straight to the column phase. A row activation costs several times the energy of a column access, so the block counts activations on an output. Software or a higher-level scheduler can use that count to judge row locality. The cell array is modelled as a behavioural storage array. Column writes update both the row buffer and the array. One busy flag covers the whole transaction, and requests that arrive while it is high are dropped.

Top module: `dram_bank_seq`

## Requirements
- R1: After reset, busy, rsp_valid and act_count are all zero and no row is open, so the first request always runs the full row cycle.
- R2: A request whose row differs from the open row passes through precharge, readout, restore and column phases, in that order. rsp_valid rises exactly T_PRE+T_SENSE+T_RESTORE+T_COL cycles after the accepting clock edge (8 with defaults).
- R3: A request to the open row skips the row phases. rsp_valid rises exactly T_COL cycles after the accepting edge (1 with defaults).
- R4: act_count increments by exactly one for each accepted request to a row that is not open, and stays unchanged for requests to the open row.
- R5: busy is high from the cycle after acceptance up to the response. rsp_valid is a one-cycle pulse, and busy is low during that pulse.
- R6: A request presented while busy is high is ignored. It produces no response and does not change act_count or the open row.
- R7: A read returns the data most recently written to the same row and column group. A write response returns the data just written.
- R8: Column group g (req_col, 3 bits) occupies row bits [g*256 +: 256]. Writing one group leaves the other groups of that row unchanged.
- R9: Data written to a row is still present after other rows have been opened and the row is reopened.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request strobe, taken when busy is low |
| req_row | input | 10 | Row address |
| req_col | input | 3 | Column group select |
| req_write | input | 1 | 1 = write, 0 = read |
| req_wdata | input | 256 | Write data |
| busy | output | 1 | Transaction in progress |
| rsp_valid | output | 1 | One-cycle response strobe |
| rsp_rdata | output | 256 | Column data (read result or written data) |
| act_count | output | 32 | Number of row activations since reset |

## Verification
A wrong open-row record shows up at the very next request. Its response arrives after 8 cycles instead of 1, or the reverse, and act_count moves when it should not, or fails to move when it should. A phase counter that loads the wrong length shifts the response edge on every miss. A row buffer that is filled from the wrong row or group returns stale data on the first hit read after that fill. Requests injected while busy is high check that dropped requests leave no trace in the count, in the response strobe or in the open-row state.

// File: rtl/dbs_pkg.sv
package dbs_pkg;

    typedef enum logic [2:0] {
        PH_IDLE    = 3'd0,
        PH_PRE     = 3'd1,
        PH_SENSE   = 3'd2,
        PH_RESTORE = 3'd3,
        PH_COL     = 3'd4
    } phase_e;

    typedef struct packed {
        logic load_row;   // row buffer captures array row
        logic col_do;     // column access completes this cycle
        logic act_inc;    // new row activation accepted
    } strobe_t;

    function automatic int unsigned max4(input int unsigned a, input int unsigned b,
                                         input int unsigned c, input int unsigned d);
        int unsigned m;
        m = a;
        if (b > m) m = b;
        if (c > m) m = c;
        if (d > m) m = d;
        return m;
    endfunction

    function automatic int unsigned miss_cycles(input int unsigned a, input int unsigned b,
                                                input int unsigned c, input int unsigned d);
        return a + b + c + d;
    endfunction

endpackage

// File: rtl/dbs_phase_timer.sv
module dbs_phase_timer #(
    parameter int unsigned TW = 2
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          start,
    input  logic [TW-1:0] len,
    output logic          last
);
    logic [TW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt <= '0;
        end else if (start) begin
            cnt <= len - TW'(1);
        end else if (cnt != '0) begin
            cnt <= cnt - TW'(1);
        end
    end

    assign last = (cnt == '0);
endmodule

// File: rtl/dbs_ctrl.sv
module dbs_ctrl
    import dbs_pkg::*;
#(
    parameter int unsigned ROW_AW    = 10,
    parameter int unsigned COL_AW    = 3,
    parameter int unsigned T_PRE     = 2,
    parameter int unsigned T_SENSE   = 2,
    parameter int unsigned T_RESTORE = 3,
    parameter int unsigned T_COL     = 1,
    parameter int unsigned TW        = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    input  logic [ROW_AW-1:0] req_row,
    input  logic [COL_AW-1:0] req_col,
    input  logic              req_write,
    input  logic              timer_last,
    output logic              timer_start,
    output logic [TW-1:0]     timer_len,
    output phase_e            phase,
    output strobe_t           strobe,
    output logic [ROW_AW-1:0] cur_row,
    output logic [COL_AW-1:0] cur_col,
    output logic              cur_write
);
    phase_e            phase_n;
    logic              row_open;
    logic [ROW_AW-1:0] open_row;
    logic              accept;
    logic              hit;

    assign accept = (phase == PH_IDLE) && req_valid;
    assign hit    = row_open && (req_row == open_row);

    always_comb begin
        phase_n = phase;
        unique case (phase)
            PH_IDLE:    if (accept)     phase_n = hit ? PH_COL : PH_PRE;
            PH_PRE:     if (timer_last) phase_n = PH_SENSE;
            PH_SENSE:   if (timer_last) phase_n = PH_RESTORE;
            PH_RESTORE: if (timer_last) phase_n = PH_COL;
            PH_COL:     if (timer_last) phase_n = PH_IDLE;
            default:                    phase_n = PH_IDLE;
        endcase
    end

    always_comb begin
        unique case (phase_n)
            PH_PRE:     timer_len = TW'(T_PRE);
            PH_SENSE:   timer_len = TW'(T_SENSE);
            PH_RESTORE: timer_len = TW'(T_RESTORE);
            default:    timer_len = TW'(T_COL);
        endcase
    end

    assign timer_start = (phase_n != phase) && (phase_n != PH_IDLE);

    always_comb begin
        strobe.load_row = (phase == PH_SENSE) && timer_last;
        strobe.col_do   = (phase == PH_COL) && timer_last;
        strobe.act_inc  = accept && !hit;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            phase     <= PH_IDLE;
            row_open  <= 1'b0;
            open_row  <= '0;
            cur_row   <= '0;
            cur_col   <= '0;
            cur_write <= 1'b0;
        end else begin
            phase <= phase_n;
            if (accept) begin
                cur_row   <= req_row;
                cur_col   <= req_col;
                cur_write <= req_write;
                if (!hit) begin
                    row_open <= 1'b1;
                    open_row <= req_row;
                end
            end
        end
    end
endmodule

// File: rtl/dbs_row_store.sv
module dbs_row_store #(
    parameter int unsigned ROWS   = 1024,
    parameter int unsigned COLS   = 2048,
    parameter int unsigned IO_W   = 256,
    parameter int unsigned ROW_AW = 10,
    parameter int unsigned COL_AW = 3
) (
    input  logic              clk,
    input  logic              load_row,
    input  logic              col_do,
    input  logic [ROW_AW-1:0] row_sel,
    input  logic [COL_AW-1:0] col_sel,
    input  logic              col_write,
    input  logic [IO_W-1:0]   wdata,
    output logic [IO_W-1:0]   rdata
);
    logic [COLS-1:0] cells [ROWS];
    logic [COLS-1:0] rbuf;

    always_ff @(posedge clk) begin
        if (load_row) begin
            rbuf <= cells[row_sel];
        end
        if (col_do) begin
            if (col_write) begin
                cells[row_sel][col_sel*IO_W +: IO_W] <= wdata;
                rbuf[col_sel*IO_W +: IO_W]           <= wdata;
                rdata                                <= wdata;
            end else begin
                rdata <= rbuf[col_sel*IO_W +: IO_W];
            end
        end
    end
endmodule

// File: rtl/dram_bank_seq.sv
module dram_bank_seq
    import dbs_pkg::*;
#(
    parameter int unsigned ROWS      = 1024,
    parameter int unsigned COLS      = 2048,
    parameter int unsigned IO_W      = 256,
    parameter int unsigned T_PRE     = 2,
    parameter int unsigned T_SENSE   = 2,
    parameter int unsigned T_RESTORE = 3,
    parameter int unsigned T_COL     = 1,
    parameter int unsigned CNT_W     = 32,
    localparam int unsigned ROW_AW   = $clog2(ROWS),
    localparam int unsigned COL_AW   = $clog2(COLS / IO_W)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    input  logic [ROW_AW-1:0] req_row,
    input  logic [COL_AW-1:0] req_col,
    input  logic              req_write,
    input  logic [IO_W-1:0]   req_wdata,
    output logic              busy,
    output logic              rsp_valid,
    output logic [IO_W-1:0]   rsp_rdata,
    output logic [CNT_W-1:0]  act_count
);
    localparam int unsigned TMAX = max4(T_PRE, T_SENSE, T_RESTORE, T_COL);
    localparam int unsigned TW   = $clog2(TMAX + 1);

    phase_e            phase;
    strobe_t           strobe;
    logic              timer_start;
    logic              timer_last;
    logic [TW-1:0]     timer_len;
    logic [ROW_AW-1:0] cur_row;
    logic [COL_AW-1:0] cur_col;
    logic              cur_write;
    logic [IO_W-1:0]   wdata_q;

    dbs_ctrl #(
        .ROW_AW(ROW_AW), .COL_AW(COL_AW),
        .T_PRE(T_PRE), .T_SENSE(T_SENSE), .T_RESTORE(T_RESTORE), .T_COL(T_COL),
        .TW(TW)
    ) u_ctrl (
        .clk(clk), .rst(rst),
        .req_valid(req_valid), .req_row(req_row), .req_col(req_col), .req_write(req_write),
        .timer_last(timer_last), .timer_start(timer_start), .timer_len(timer_len),
        .phase(phase), .strobe(strobe),
        .cur_row(cur_row), .cur_col(cur_col), .cur_write(cur_write)
    );

    dbs_phase_timer #(.TW(TW)) u_timer (
        .clk(clk), .rst(rst), .start(timer_start), .len(timer_len), .last(timer_last)
    );

    dbs_row_store #(
        .ROWS(ROWS), .COLS(COLS), .IO_W(IO_W), .ROW_AW(ROW_AW), .COL_AW(COL_AW)
    ) u_store (
        .clk(clk), .load_row(strobe.load_row), .col_do(strobe.col_do),
        .row_sel(cur_row), .col_sel(cur_col), .col_write(cur_write),
        .wdata(wdata_q), .rdata(rsp_rdata)
    );

    always_ff @(posedge clk) begin
        if ((phase == PH_IDLE) && req_valid) begin
            wdata_q <= req_wdata;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rsp_valid <= 1'b0;
            act_count <= '0;
        end else begin
            rsp_valid <= strobe.col_do;
            if (strobe.act_inc) begin
                act_count <= act_count + CNT_W'(1);
            end
        end
    end

    assign busy = (phase != PH_IDLE);
endmodule

// File: rtl/dbs_checker.sv
module dbs_checker
    import dbs_pkg::*;
#(
    parameter int unsigned T_COL = 1,
    parameter int unsigned MISS  = 8,
    parameter int unsigned CNT_W = 32
) (
    input logic             clk,
    input logic             rst,
    input logic             req_valid,
    input logic             busy,
    input logic             rsp_valid,
    input logic [CNT_W-1:0] act_count,
    input phase_e           phase
);
    logic [15:0] run_len;

    always_ff @(posedge clk) begin
        if (rst)       run_len <= '0;
        else if (busy) run_len <= run_len + 16'd1;
        else           run_len <= '0;
    end

    assert_reset_state_R1: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (!busy && !rsp_valid && act_count == '0));

    assert_phase_order_R2: assert property (@(posedge clk) disable iff (rst)
        (phase != $past(phase)) |->
            ((phase == PH_PRE     && $past(phase) == PH_IDLE)  ||
             (phase == PH_SENSE   && $past(phase) == PH_PRE)   ||
             (phase == PH_RESTORE && $past(phase) == PH_SENSE) ||
             (phase == PH_COL     && ($past(phase) == PH_RESTORE || $past(phase) == PH_IDLE)) ||
             (phase == PH_IDLE    && $past(phase) == PH_COL)));

    // R2 and R3: response comes after exactly a hit or a miss latency
    assert_latency_R3: assert property (@(posedge clk) disable iff (rst)
        rsp_valid |-> (run_len == 16'(T_COL) || run_len == 16'(MISS)));

    assert_act_step_R4: assert property (@(posedge clk) disable iff (rst)
        (act_count == $past(act_count)) || (act_count == $past(act_count) + CNT_W'(1)));

    assert_rsp_not_busy_R5: assert property (@(posedge clk) disable iff (rst)
        rsp_valid |-> !busy);

    assert_busy_ends_rsp_R5: assert property (@(posedge clk) disable iff (rst)
        $fell(busy) |-> rsp_valid);

    assert_rsp_pulse_R5: assert property (@(posedge clk) disable iff (rst)
        rsp_valid |=> !rsp_valid);

    assert_accept_busy_R5: assert property (@(posedge clk) disable iff (rst)
        (req_valid && !busy) |=> busy);

    assert_ignore_busy_R6: assert property (@(posedge clk) disable iff (rst)
        busy |=> (act_count == $past(act_count)));
endmodule

bind dram_bank_seq dbs_checker #(
    .T_COL(T_COL),
    .MISS(T_PRE + T_SENSE + T_RESTORE + T_COL),
    .CNT_W(CNT_W)
) chk_i (
    .clk(clk), .rst(rst), .req_valid(req_valid), .busy(busy),
    .rsp_valid(rsp_valid), .act_count(act_count), .phase(phase)
);

// File: tb/dram_bank_seq_tb.sv
module dram_bank_seq_tb_top;
    localparam int TP = 2, TS = 2, TR = 3, TC = 1;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         req_valid = 1'b0;
    logic [9:0]   req_row = '0;
    logic [2:0]   req_col = '0;
    logic         req_write = 1'b0;
    logic [255:0] req_wdata = '0;
    logic         busy;
    logic         rsp_valid;
    logic [255:0] rsp_rdata;
    logic [31:0]  act_count;

    int vectors = 0;
    int errors  = 0;
    logic [255:0] model [int];
    bit   open_valid = 1'b0;
    int   open_row   = 0;
    int   exp_act    = 0;

    always #5 clk = ~clk;

    dram_bank_seq dut_i (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_row(req_row), .req_col(req_col),
        .req_write(req_write), .req_wdata(req_wdata), .busy(busy), .rsp_valid(rsp_valid),
        .rsp_rdata(rsp_rdata), .act_count(act_count)
    );

    function automatic int exp_latency(input bit is_hit);
        return is_hit ? TC : (TP + TS + TR + TC);
    endfunction

    function automatic logic [255:0] rand256();
        logic [255:0] v;
        for (int i = 0; i < 8; i++) v[i*32 +: 32] = $urandom;
        return v;
    endfunction

    task automatic chk(input string req, input logic [255:0] got, input logic [255:0] exp);
        vectors++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, got, exp);
        end
    endtask

    task automatic do_op(input int row, input int col, input bit wr, input logic [255:0] wd,
                         input bit inject, input int inj_row);
        bit hit;
        int lat;
        bit got;
        int key;
        hit = open_valid && (open_row == row);
        key = row * 8 + col;
        @(negedge clk);
        req_valid = 1'b1; req_row = 10'(row); req_col = 3'(col);
        req_write = wr; req_wdata = wd;
        @(negedge clk);
        req_valid = 1'b0;
        chk("R5 busy after accept", 256'(busy), 256'(1));
        lat = 0; got = 1'b0;
        while (!got && lat < 64) begin
            if (inject && lat == 2) begin
                req_valid = 1'b1; req_row = 10'(inj_row); req_write = 1'b0;
            end else begin
                req_valid = 1'b0;
            end
            @(negedge clk);
            lat++;
            if (rsp_valid) got = 1'b1;
        end
        req_valid = 1'b0;
        if (hit) chk("R3 hit latency", 256'(lat), 256'(exp_latency(1'b1)));
        else     chk("R2 miss latency", 256'(lat), 256'(exp_latency(1'b0)));
        chk("R5 busy low in response cycle", 256'(busy), 256'(0));
        if (!hit) begin
            exp_act++;
            open_valid = 1'b1;
            open_row   = row;
        end
        chk("R4 activation count", 256'(act_count), 256'(exp_act));
        if (wr) begin
            chk("R7 write response data", rsp_rdata, wd);
            model[key] = wd;
        end else if (model.exists(key)) begin
            chk("R7/R8/R9 read data", rsp_rdata, model[key]);
        end
        @(negedge clk);
        chk("R5 response is one pulse", 256'(rsp_valid), 256'(0));
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
        $finish;
    end

    initial begin
        logic [255:0] da, db, dc;
        void'($urandom(32'd12345));
        da = rand256(); db = rand256(); dc = rand256();
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk("R1 busy after reset", 256'(busy), 256'(0));
        chk("R1 rsp_valid after reset", 256'(rsp_valid), 256'(0));
        chk("R1 act_count after reset", 256'(act_count), 256'(0));

        do_op(5, 0, 1'b1, da, 1'b0, 0);        // R1 first access is a miss
        do_op(5, 0, 1'b0, '0, 1'b0, 0);        // R3 hit read
        do_op(5, 7, 1'b1, db, 1'b0, 0);        // R8 top group
        do_op(5, 7, 1'b0, '0, 1'b0, 0);
        do_op(5, 0, 1'b0, '0, 1'b0, 0);        // R8 group 0 untouched
        do_op(1023, 3, 1'b1, dc, 1'b1, 5);     // R6 request injected while busy
        repeat (3) begin
            @(negedge clk);
            chk("R6 no response from ignored request", 256'(rsp_valid), 256'(0));
        end
        chk("R6 act_count after ignored request", 256'(act_count), 256'(exp_act));
        do_op(1023, 3, 1'b0, '0, 1'b0, 0);     // R6 row 1023 still open: hit
        do_op(5, 0, 1'b0, '0, 1'b0, 0);        // R9 reopen keeps data
        do_op(5, 7, 1'b0, '0, 1'b0, 0);

        for (int n = 0; n < 400; n++) begin
            int sel;
            int row;
            sel = int'($urandom % 6);
            case (sel)
                0: row = 0;
                1: row = 5;
                2: row = 1023;
                3: row = open_row;
                default: row = int'($urandom % 1024);
            endcase
            do_op(row, int'($urandom % 8), bit'($urandom % 2), rand256(),
                  ($urandom % 8) == 0, int'($urandom % 1024));
        end

        $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
        $finish;
    end
endmodule